// File: doc/BRIEF.md
# Relative Seconds Countdown Alarm

This block counts down a software-loaded number of seconds and raises a pending flag when the count expires. A register bus loads the count and reads back the seconds still remaining. It also controls three single-bit enables: one that lets the count run, one that gates an interrupt line, and one that gates a wakeup line. A one-cycle pulse on the seconds tick input advances the count.

To arm a new alarm, software first clears the run bit and the pending flag and writes zero to the count. It then writes the new span and sets the run bit. The remaining count falls by one on each tick. When it goes from one to zero, the pending flag is set, and the count then holds at zero. The pending flag is cleared by writing a one to bit 0 of the status register. The interrupt and wakeup outputs are the pending flag masked by their own enable bits.

Top module: `countdown_alarm`

## Requirements
- R1: After reset the remaining count, the loaded value, the run, interrupt-enable and wakeup-enable bits and the pending flag are all zero, and irq_o and wake_o are low.
- R2: A write to word address 0 (span) stores the 32-bit value. From the next cycle, a read of address 0 returns it and a read of address 1 (remaining) returns it as the remaining count. When a span write and a tick fall in the same cycle, the written value wins.
- R3: While bit 0 of address 2 (run) is 1, each tick lowers the remaining count by one. While the run bit is 0, ticks leave the count unchanged.
- R4: When a tick takes the remaining count from 1 to 0 with run set, bit 0 of address 4 (status) reads 1 from the next cycle. The count then stays at 0 under further ticks.
- R5: Loading a span of 0 while run is set never sets the pending flag, even if ticks arrive afterwards.
- R6: Writing a value with bit 0 set to address 4 clears the pending flag. Writing a value with bit 0 clear leaves it set.
- R7: When a clear write to address 4 and the expiry tick fall in the same cycle, the pending flag ends up set.
- R8: irq_o is high exactly when the pending flag and bit 0 of address 3 (interrupt enable) are both 1.
- R9: wake_o is high exactly when the pending flag and bit 0 of address 5 (wakeup enable) are both 1.
- R10: The full 32-bit span is honoured: a load of 0xFFFFFFFF reads back unchanged, and one tick takes it to 0xFFFFFFFE.
- R11: Reads of the unused addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The hardest case to reach is the race between a write-one-to-clear of the pending flag and the tick that expires the count. Reaching it needs a span of exactly one, the run bit set, and the clear write presented on the same clock edge as the tick. The bench drives both from one negative edge so that they share the edge. It then reads the status register to check that the set won. The same pairing of a span write with a tick shows that the load has priority over the decrement.

// File: rtl/countdown_alarm.sv
module countdown_alarm #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  localparam logic [ADDR_W-1:0] A_SPAN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LEFT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_WEN  = ADDR_W'(5);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0]  ZERO   = '0;

  logic [CNT_W-1:0] span_q, left_q;
  logic run_q, ien_q, wen_q, pend_q;
  logic ld, step, hit, clr;

  assign ld   = bus_we && (bus_addr == A_SPAN);
  assign step = run_q && sec_tick && (left_q != ZERO) && !ld;
  assign hit  = step && (left_q == ONE);
  assign clr  = bus_we && (bus_addr == A_STAT) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_q <= ZERO;
      left_q <= ZERO;
    end else if (ld) begin
      span_q <= bus_wdata;
      left_q <= bus_wdata;
    end else if (step) begin
      left_q <= left_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
      wen_q <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_RUN) run_q <= bus_wdata[0];
      if (bus_addr == A_IEN) ien_q <= bus_wdata[0];
      if (bus_addr == A_WEN) wen_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign irq_o  = pend_q & ien_q;
  assign wake_o = pend_q & wen_q;

  always_comb begin
    case (bus_addr)
      A_SPAN:  bus_rdata = span_q;
      A_LEFT:  bus_rdata = left_q;
      A_RUN:   bus_rdata = {{(CNT_W-1){1'b0}}, run_q};
      A_IEN:   bus_rdata = {{(CNT_W-1){1'b0}}, ien_q};
      A_STAT:  bus_rdata = {{(CNT_W-1){1'b0}}, pend_q};
      A_WEN:   bus_rdata = {{(CNT_W-1){1'b0}}, wen_q};
      default: bus_rdata = ZERO;
    endcase
  end

  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (left_q == $past(bus_wdata)) && (span_q == $past(bus_wdata)));

  a_r3_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && sec_tick && left_q != ZERO && !ld) |=> (left_q == $past(left_q) - ONE));

  a_r3_paused: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ld) |=> $stable(left_q));

  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == ZERO && !ld) |=> (left_q == ZERO));

  a_r4_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && sec_tick && left_q == ONE && !ld) |=> pend_q);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !pend_q);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q && ien_q));

  a_r9_wake_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (pend_q && wen_q));
endmodule

// File: tb/countdown_alarm_tb.sv
module countdown_alarm_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  countdown_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic arm(input logic [31:0] span);
    wr(3'd2, 32'd0); wr(3'd4, 32'd1); wr(3'd0, 32'd0);
    wr(3'd0, span); wr(3'd2, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reset register", v, 32'd0);
    end
    chk("R1 irq_o at reset", {31'd0, irq_o}, 32'd0);
    chk("R1 wake_o at reset", {31'd0, wake_o}, 32'd0);
  endtask

  task automatic t_load_read;
    logic [31:0] v;
    wr(3'd0, 32'h0000_1234);
    rd(3'd0, v); chk("R2 span readback", v, 32'h0000_1234);
    rd(3'd1, v); chk("R2 remaining after load", v, 32'h0000_1234);
    rd(3'd6, v); chk("R11 unused addr 6", v, 32'd0);
    rd(3'd7, v); chk("R11 unused addr 7", v, 32'd0);
  endtask

  task automatic t_countdown;
    logic [31:0] v;
    arm(32'd10);
    tick(3);
    rd(3'd1, v); chk("R3 three ticks", v, 32'd7);
    wr(3'd2, 32'd0);
    tick(4);
    rd(3'd1, v); chk("R3 ticks ignored while paused", v, 32'd7);
    wr(3'd2, 32'd1);
    tick(1);
    rd(3'd1, v); chk("R3 resumes", v, 32'd6);
  endtask

  task automatic t_expire;
    logic [31:0] v;
    arm(32'd2);
    tick(1);
    rd(3'd4, v); chk("R4 not pending early", v, 32'd0);
    tick(1);
    rd(3'd4, v); chk("R4 pending on expiry", v, 32'd1);
    tick(3);
    rd(3'd1, v); chk("R4 holds at zero", v, 32'd0);
    wr(3'd4, 32'd0);
    rd(3'd4, v); chk("R6 write of 0 keeps pending", v, 32'd1);
    wr(3'd4, 32'd1);
    rd(3'd4, v); chk("R6 write-one clears", v, 32'd0);
  endtask

  task automatic t_load_zero;
    logic [31:0] v;
    arm(32'd0);
    tick(3);
    rd(3'd4, v); chk("R5 zero span never pends", v, 32'd0);
  endtask

  task automatic t_clear_race;
    logic [31:0] v;
    arm(32'd1);
    @(negedge clk);
    sec_tick = 1'b1; bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 32'd1;
    @(negedge clk);
    sec_tick = 1'b0; bus_we = 1'b0;
    rd(3'd4, v); chk("R7 set wins over clear", v, 32'd1);
  endtask

  task automatic t_outputs;
    arm(32'd1);
    wr(3'd3, 32'd0); wr(3'd5, 32'd0);
    tick(1);
    #1;
    chk("R8 irq masked", {31'd0, irq_o}, 32'd0);
    chk("R9 wake masked", {31'd0, wake_o}, 32'd0);
    wr(3'd3, 32'd1);
    #1;
    chk("R8 irq raised", {31'd0, irq_o}, 32'd1);
    chk("R9 wake still masked", {31'd0, wake_o}, 32'd0);
    wr(3'd5, 32'd1);
    #1;
    chk("R9 wake raised", {31'd0, wake_o}, 32'd1);
    wr(3'd4, 32'd1);
    #1;
    chk("R8 irq drops on clear", {31'd0, irq_o}, 32'd0);
    chk("R9 wake drops on clear", {31'd0, wake_o}, 32'd0);
    wr(3'd3, 32'd0); wr(3'd5, 32'd0);
  endtask

  task automatic t_full_span;
    logic [31:0] v;
    arm(32'hFFFF_FFFF);
    rd(3'd1, v); chk("R10 full span loads", v, 32'hFFFF_FFFF);
    tick(1);
    rd(3'd1, v); chk("R10 full span decrements", v, 32'hFFFF_FFFE);
  endtask

  task automatic t_load_vs_tick;
    logic [31:0] v;
    arm(32'd50);
    @(negedge clk);
    sec_tick = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'd20;
    @(negedge clk);
    sec_tick = 1'b0; bus_we = 1'b0;
    rd(3'd1, v); chk("R2 load beats tick", v, 32'd20);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_read();
    t_countdown();
    t_expire();
    t_load_zero();
    t_clear_race();
    t_outputs();
    t_full_span();
    t_load_vs_tick();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule